// File: doc/BRIEF.md
# Coulomb Accumulator with Periodic Offset Calibration

This block integrates signed current readings into a signed charge register. A converter delivers one raw reading per conversion, signalled by a single-cycle done strobe and a flag that marks the conversion as an offset measurement rather than a sense reading. Sense readings have the latest measured offset subtracted and are clamped to the sample width. The result is shown on the current output and summed into a wide internal accumulator. The top bits of that accumulator form the host-visible charge register, and the low bits are a hidden fraction.

A conversion counter asks the converter for an offset measurement on one conversion in every calibration period. In that slot no sense reading exists. The previous corrected current is therefore held on the current output and added to the charge in place of the missing reading. A host write loads the integer part of the charge, clears the hidden fraction and requests an immediate offset measurement. The conversion that follows the write only recalibrates, and integration resumes with the second conversion after the write.

Top module: `coulomb_accum`

## Requirements
- R1: On a sense conversion, the current output becomes raw minus stored offset, clamped to the signed range of SAMPLE_W bits (two's complement). It is valid on the clock edge that samples the strobe.
- R2: On a conversion flagged as offset, the raw value becomes the stored offset and the current output keeps its previous value.
- R3: On a flagged offset conversion outside a restart, the held current value is added into the accumulator in place of a sample.
- R4: The accumulator is ACC_W+FRAC_W bits wide. Each addend lands at the fraction LSB, and the charge output is the top ACC_W bits (with defaults, 4096 unit samples raise the charge by 1).
- R5: With SATURATE=1 the accumulator clamps at its largest positive and most negative values instead of wrapping.
- R6: The offset request is high when the conversion counter is zero. The counter advances by one per conversion, modulo CAL_PERIOD. After reset the counter is 1, so the first request comes after CAL_PERIOD-1 conversions, and the offset is zero until the first offset conversion.
- R7: A host write loads the charge output with the write data, clears the fraction and zeroes the counter, so the offset request is high on the next cycle.
- R8: The first conversion after a host write changes neither charge nor current. If it is flagged as offset it still updates the stored offset. Integration resumes with the second conversion.
- R9: When a host write and a conversion strobe fall in the same cycle, the write takes effect and the conversion is discarded, without advancing the counter.
- R10: After reset, current, charge and stored offset are zero and the offset request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has finished |
| conv_is_offset | input | 1 | Finished conversion was an offset measurement |
| raw_sample | input | SAMPLE_W | Signed raw converter value |
| host_wr | input | 1 | Host write strobe for the charge register |
| host_wdata | input | ACC_W | Signed charge value to load |
| current_out | output | SAMPLE_W | Signed corrected current register |
| charge_out | output | ACC_W | Signed integer part of the accumulated charge |
| offset_req | output | 1 | Next conversion should measure offset |

## Verification
A host write can land in the same cycle as a conversion strobe, and the two then compete for the accumulator, the counter and the current register. The bench provokes this by raising both strobes together while the hidden fraction is non-zero and the conversion would otherwise have been a sense reading. A model computed from the requirements judges the result: the charge must equal the written value with a cleared fraction, the current must stay unchanged, and the offset request must rise. The conversion after the collision is then checked to act as the restart slot.

// File: rtl/coulomb_pkg.sv
package coulomb_pkg;
   // Classification of the conversion seen in a given cycle.
   typedef enum logic [2:0] {
      CK_NONE,      // no conversion, or discarded by a host write
      CK_SAMPLE,    // sense reading, corrected and integrated
      CK_OFFSET,    // offset measurement, held current substituted
      CK_CAL_ONLY,  // offset measurement in the restart slot, no integration
      CK_SKIP       // sense reading in the restart slot, dropped
   } conv_kind_e;
endpackage

// File: rtl/cal_sequencer.sv
module cal_sequencer
   import coulomb_pkg::*;
#(
   parameter int CAL_PERIOD = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       conv_done,
   input  logic       conv_is_offset,
   input  logic       host_wr,
   output logic       offset_req,
   output conv_kind_e kind
);
   localparam int CNT_W = (CAL_PERIOD > 2) ? $clog2(CAL_PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CAL_PERIOD - 1);
   localparam logic [CNT_W-1:0] RESET_CNT = CNT_W'(1);

   if (CAL_PERIOD < 2) begin : g_bad_period
      $error("cal_sequencer: CAL_PERIOD must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             restart_q;

   always_comb begin
      kind = CK_NONE;
      if (conv_done && !host_wr) begin
         if (restart_q) kind = conv_is_offset ? CK_CAL_ONLY : CK_SKIP;
         else           kind = conv_is_offset ? CK_OFFSET : CK_SAMPLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= RESET_CNT;
         restart_q <= 1'b0;
      end else if (host_wr) begin
         cnt_q     <= '0;
         restart_q <= 1'b1;
      end else if (conv_done) begin
         cnt_q     <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
         restart_q <= 1'b0;
      end
   end

   assign offset_req = (cnt_q == '0);

   p_req_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> offset_req);

   p_req_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !host_wr && offset_req) |=> !offset_req);

   p_idle_keeps_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!conv_done && !host_wr) |=> $stable(offset_req));
endmodule

// File: rtl/offset_corrector.sv
module offset_corrector
   import coulomb_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  conv_kind_e                 kind,
   input  logic signed [SAMPLE_W-1:0] raw_sample,
   output logic signed [SAMPLE_W-1:0] cur_q,
   output logic                       add_en,
   output logic signed [SAMPLE_W-1:0] addend
);
   localparam int DW = SAMPLE_W + 1;
   localparam logic signed [SAMPLE_W-1:0] POS_LIM = {1'b0, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [SAMPLE_W-1:0] NEG_LIM = {1'b1, {(SAMPLE_W-1){1'b0}}};

   if (SAMPLE_W < 2) begin : g_bad_width
      $error("offset_corrector: SAMPLE_W must be at least 2");
   end

   logic signed [SAMPLE_W-1:0] off_q;
   logic signed [DW-1:0]       diff;
   logic signed [SAMPLE_W-1:0] corr;

   always_comb begin
      diff = {raw_sample[SAMPLE_W-1], raw_sample} - {off_q[SAMPLE_W-1], off_q};
      if (diff[DW-1] != diff[DW-2]) corr = diff[DW-1] ? NEG_LIM : POS_LIM;
      else                          corr = diff[SAMPLE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         off_q <= '0;
      end else begin
         case (kind)
            CK_SAMPLE:              cur_q <= corr;
            CK_OFFSET, CK_CAL_ONLY: off_q <= raw_sample;
            default: ;
         endcase
      end
   end

   assign add_en = (kind == CK_SAMPLE) || (kind == CK_OFFSET);
   assign addend = (kind == CK_OFFSET) ? cur_q : corr;

   p_cur_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CK_OFFSET || kind == CK_CAL_ONLY) |=> $stable(cur_q));

   p_no_wrap_pos_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CK_SAMPLE && !raw_sample[SAMPLE_W-1] && (off_q[SAMPLE_W-1] || off_q == '0))
      |=> !cur_q[SAMPLE_W-1]);

   p_no_wrap_neg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CK_SAMPLE && raw_sample[SAMPLE_W-1] && !off_q[SAMPLE_W-1])
      |=> cur_q[SAMPLE_W-1]);
endmodule

// File: rtl/charge_integrator.sv
module charge_integrator #(
   parameter int SAMPLE_W = 16,
   parameter int ACC_W    = 16,
   parameter int FRAC_W   = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       add_en,
   input  logic signed [SAMPLE_W-1:0] addend,
   input  logic                       host_wr,
   input  logic [ACC_W-1:0]           host_wdata,
   output logic [ACC_W-1:0]           charge_out
);
   localparam int FULL_W = ACC_W + FRAC_W;
   localparam int EXT_W  = FULL_W + 1 - SAMPLE_W;
   localparam logic [FULL_W-1:0] TOP_VAL = {1'b0, {(FULL_W-1){1'b1}}};
   localparam logic [FULL_W-1:0] BOT_VAL = {1'b1, {(FULL_W-1){1'b0}}};

   if (FRAC_W < 1 || SAMPLE_W > FULL_W) begin : g_bad_cfg
      $error("charge_integrator: need FRAC_W >= 1 and SAMPLE_W <= ACC_W + FRAC_W");
   end

   logic [FULL_W-1:0] acc_q;
   logic [FULL_W-1:0] acc_next;
   logic [FULL_W:0]   sum;

   assign sum = {acc_q[FULL_W-1], acc_q} + {{EXT_W{addend[SAMPLE_W-1]}}, addend};

   if (SATURATE) begin : g_clamp
      always_comb begin
         if (sum[FULL_W] != sum[FULL_W-1]) acc_next = sum[FULL_W] ? BOT_VAL : TOP_VAL;
         else                              acc_next = sum[FULL_W-1:0];
      end

      p_no_wrap_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (add_en && !host_wr && !acc_q[FULL_W-1] && !addend[SAMPLE_W-1]) |=> !acc_q[FULL_W-1]);

      p_no_wrap_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (add_en && !host_wr && acc_q[FULL_W-1] && addend[SAMPLE_W-1]) |=> acc_q[FULL_W-1]);
   end else begin : g_wrap
      assign acc_next = sum[FULL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (host_wr) acc_q <= {host_wdata, {FRAC_W{1'b0}}};
      else if (add_en)  acc_q <= acc_next;
   end

   assign charge_out = acc_q[FULL_W-1 -: ACC_W];

   p_write_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> (charge_out == $past(host_wdata)) && (acc_q[FRAC_W-1:0] == '0));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!add_en && !host_wr) |=> $stable(acc_q));
endmodule

// File: rtl/coulomb_accum.sv
module coulomb_accum
   import coulomb_pkg::*;
#(
   parameter int SAMPLE_W   = 16,
   parameter int ACC_W      = 16,
   parameter int FRAC_W     = 12,
   parameter int CAL_PERIOD = 1024,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_done,
   input  logic                conv_is_offset,
   input  logic [SAMPLE_W-1:0] raw_sample,
   input  logic                host_wr,
   input  logic [ACC_W-1:0]    host_wdata,
   output logic [SAMPLE_W-1:0] current_out,
   output logic [ACC_W-1:0]    charge_out,
   output logic                offset_req
);
   conv_kind_e                 kind;
   logic signed [SAMPLE_W-1:0] cur_s;
   logic signed [SAMPLE_W-1:0] addend;
   logic                       add_en;

   cal_sequencer #(.CAL_PERIOD(CAL_PERIOD)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .conv_done      (conv_done),
      .conv_is_offset (conv_is_offset),
      .host_wr        (host_wr),
      .offset_req     (offset_req),
      .kind           (kind)
   );

   offset_corrector #(.SAMPLE_W(SAMPLE_W)) u_corr (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .raw_sample ($signed(raw_sample)),
      .cur_q      (cur_s),
      .add_en     (add_en),
      .addend     (addend)
   );

   charge_integrator #(
      .SAMPLE_W (SAMPLE_W),
      .ACC_W    (ACC_W),
      .FRAC_W   (FRAC_W),
      .SATURATE (SATURATE)
   ) u_int (
      .clk        (clk),
      .rst_n      (rst_n),
      .add_en     (add_en),
      .addend     (addend),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .charge_out (charge_out)
   );

   assign current_out = cur_s;

   p_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && host_wr) |=> $stable(current_out) && offset_req);

   p_restart_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CK_SKIP || kind == CK_CAL_ONLY) |=> $stable(charge_out) && $stable(current_out));
endmodule

// File: tb/tb_coulomb_accum.sv
`timescale 1ns/1ps
module tb_coulomb_accum;
   localparam int  P      = 8;
   localparam int  FRAC   = 12;
   localparam int  FULL   = 28;
   localparam longint AMAX = (longint'(1) <<< (FULL-1)) - 1;
   localparam longint AMIN = -(longint'(1) <<< (FULL-1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_done = 1'b0, conv_is_offset = 1'b0, host_wr = 1'b0;
   logic [15:0] raw_sample = '0, host_wdata = '0;
   logic [15:0] current_out, charge_out;
   logic offset_req;

   int checks = 0, errors = 0;
   bit finished = 0;

   longint m_acc = 0, m_cur = 0, m_off = 0;
   int     m_cnt = 1;
   bit     m_restart = 0;

   always #2 clk = ~clk;

   coulomb_accum #(.CAL_PERIOD(P), .FRAC_W(FRAC)) dut (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_is_offset(conv_is_offset),
      .raw_sample(raw_sample), .host_wr(host_wr), .host_wdata(host_wdata),
      .current_out(current_out), .charge_out(charge_out), .offset_req(offset_req));

   function automatic longint sat16(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic longint clampacc(input longint v);
      if (v > AMAX) return AMAX;
      if (v < AMIN) return AMIN;
      return v;
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " current_out"}, longint'($signed(current_out)), m_cur);
      chk({tag, " charge_out"}, longint'($signed(charge_out)), m_acc >>> FRAC);
      chk({tag, " offset_req (R6)"}, longint'(offset_req), longint'(m_cnt == 0));
   endtask

   // One operation: optional conversion, optional host write, then model update.
   task automatic op(input bit cv, input logic [15:0] r, input logic flag,
                     input bit wr, input logic [15:0] wd);
      longint rv;
      @(negedge clk);
      conv_done = cv; conv_is_offset = flag; raw_sample = r;
      host_wr = wr; host_wdata = wd;
      @(negedge clk);
      conv_done = 1'b0; host_wr = 1'b0;
      rv = longint'($signed(r));
      if (wr) begin
         m_acc = longint'($signed(wd)) <<< FRAC;
         m_cnt = 0;
         m_restart = 1;
      end else if (cv) begin
         if (m_restart) begin
            if (flag) m_off = rv;
            m_restart = 0;
         end else if (flag) begin
            m_off = rv;
            m_acc = clampacc(m_acc + m_cur);
         end else begin
            m_cur = sat16(rv - m_off);
            m_acc = clampacc(m_acc + m_cur);
         end
         m_cnt = (m_cnt + 1) % P;
      end
   endtask

   task automatic conv_auto(input logic [15:0] r);
      op(1'b1, r, logic'(m_cnt == 0), 1'b0, 16'h0);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check_all("R10 reset");

      // R1/R6: before the first offset slot the offset is zero, current equals raw
      for (int i = 0; i < P - 1; i++) begin
         conv_auto(16'(i * 9001 - 20000));
         check_all("R1 R6 zero-offset");
      end
      chk("R6 first request after P-1 conversions", longint'(offset_req), 1);

      // R2/R3: offset slot holds current and substitutes it into the sum
      conv_auto(16'd100);
      check_all("R2 R3 offset slot");

      // R1..R4: long sweep including extremes and many offset slots
      for (int i = 0; i < 240; i++) begin
         logic [15:0] r;
         r = 16'(i * 12345 + 777);
         if (i % 17 == 0) r = 16'h7FFF;
         if (i % 19 == 0) r = 16'h8000;
         conv_auto(r);
         check_all("R1 R2 R3 R4 sweep");
      end

      // R4: fraction carry, 1024 * 4 = one charge LSB
      op(1'b0, 16'h0, 1'b0, 1'b1, 16'h0);
      check_all("R7 write zero");
      conv_auto(16'h0);                         // restart slot, offset := 0
      check_all("R8 restart cal");
      for (int i = 0; i < 4; i++) begin
         conv_auto(16'd1024);
         check_all("R4 fraction carry");
      end
      conv_auto(16'd2048);                      // leave a half-LSB fraction
      check_all("R4 half fraction");

      // R9: write and conversion together; write wins
      op(1'b1, 16'd5000, 1'b0, 1'b1, 16'd5);
      check_all("R9 collision");
      // R8: restart slot with a sense reading is dropped
      op(1'b1, 16'd3000, 1'b0, 1'b0, 16'h0);
      check_all("R8 restart skip");
      conv_auto(16'd2048);                      // fraction was cleared: stays 5
      check_all("R7 fraction cleared");
      chk("R7 charge after cleared fraction", longint'($signed(charge_out)), 5);

      // R5: positive saturation
      op(1'b0, 16'h0, 1'b0, 1'b1, 16'h7FFF);
      conv_auto(16'h0);
      for (int i = 0; i < 3; i++) begin
         conv_auto(16'h7FFF);
         check_all("R5 positive clamp");
      end
      chk("R5 charge at positive limit", longint'($signed(charge_out)), 32767);

      // R5: negative saturation
      op(1'b0, 16'h0, 1'b0, 1'b1, 16'h8000);
      conv_auto(16'h0);
      for (int i = 0; i < 3; i++) begin
         conv_auto(16'h8000);
         check_all("R5 negative clamp");
      end
      chk("R5 charge at negative limit", longint'($signed(charge_out)), -32768);

      // R1: clamp of corrected current with a large negative offset
      for (int i = 0; i < 2 * P; i++) begin
         conv_auto((m_cnt == 0) ? 16'h8100 : 16'h7F00);
         check_all("R1 current clamp");
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule